// File: doc/BRIEF.md
# Floppy Controller Cartridge Bus Decoder

This block sits between a CPU bus and a floppy-disk controller inside a plug-in cartridge. It decodes single-cycle read and write strobes. A window of four addresses is forwarded to the controller's register port. Two write-only addresses drive latches for the disk side, a one-hot drive select and the spindle motor. One read-only address reports the controller's two request lines as an active-low status byte. Every other read returns a byte from the cartridge ROM.

The ROM is modelled by a computed pattern, so a bench can predict every byte without a content file. Read data is registered: the byte chosen in a read-strobe cycle appears on `bus_rdata` from the next clock edge and holds until the next read. The controller port is combinational, so the controller sees chip-select, register index and write data in the same cycle as the bus strobe.

Top module: `fdc_glue_top`

## Requirements
- R1: `fdc_cs` is high in exactly those cycles where `bus_rd` or `bus_wr` is high with `bus_addr` in 0x7FF8..0x7FFB. In those cycles `fdc_reg` equals `bus_addr[1:0]`, `fdc_we` equals `bus_wr` and `fdc_wdata` equals `bus_wdata`.
- R2: A read strobe in 0x7FF8..0x7FFB places the `fdc_rdata` value from the strobe cycle on `bus_rdata` after the next clock edge.
- R3: A write to 0x7FFC loads `side_sel` with data bit 0, visible after the clock edge.
- R4: A write to 0x7FFD sets `drive_sel` to 2'b01 when data bit 0 is 0 and to 2'b10 when it is 1. Bit i of `drive_sel` selects drive i, and exactly one bit is ever set.
- R5: The same write to 0x7FFD loads `motor_on` with data bit 7. The one output serves all drives.
- R6: A read of 0x7FFF returns bit 7 = NOT `fdc_drq`, bit 6 = NOT `fdc_irq` and bits 5..0 = 0, sampled in the strobe cycle.
- R7: A read of any other address returns the ROM byte at `bus_addr[13:0]`. The modelled ROM byte at index a is a[7:0] XOR {2'b00, a[13:8]}.
- R8: Writes outside 0x7FF8..0x7FFD leave `side_sel`, `drive_sel` and `motor_on` unchanged and do not raise `fdc_cs`.
- R9: After reset, `side_sel` = 0, `drive_sel` = 2'b01, `motor_on` = 0 and `bus_rdata` = 0.
- R10: `bus_rdata` changes only after a cycle with `bus_rd` high. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Registered read data |
| fdc_cs | output | 1 | Controller chip-select |
| fdc_we | output | 1 | Controller write enable |
| fdc_reg | output | 2 | Controller register index |
| fdc_wdata | output | 8 | Data to controller |
| fdc_rdata | input | 8 | Data from controller |
| fdc_drq | input | 1 | Controller data request, active high |
| fdc_irq | input | 1 | Controller interrupt request, active high |
| side_sel | output | 1 | Head side select |
| drive_sel | output | 2 | One-hot drive select |
| motor_on | output | 1 | Motor enable for all drives |

## Verification
The assertions assume that the CPU never raises `bus_rd` and `bus_wr` in the same cycle, and one of them checks that assumption. They also assume that strobes last one cycle, with address and data stable while the strobe is high. The bench drives each strobe for exactly one cycle from a falling edge, and never overlaps a read with a write. It sweeps every one of the 65536 read addresses, all four request-line combinations and both values of each latch bit.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_FDC    = 3'd1,
      SEL_HEAD   = 3'd2,
      SEL_DRIVE  = 3'd3,
      SEL_STATUS = 3'd4
   } region_e;

endpackage

// File: rtl/fdc_glue_decode.sv
module fdc_glue_decode
   import fdc_glue_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned FDC_BASE = 'h7FF8
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FDC_BASE);
   localparam logic [ADDR_W-1:0] HEAD_A = ADDR_W'(FDC_BASE + 4);
   localparam logic [ADDR_W-1:0] DRV_A  = ADDR_W'(FDC_BASE + 5);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(FDC_BASE + 7);

   if (FDC_BASE % 4 != 0) begin : g_bad_align
      $error("FDC_BASE must be aligned to four bytes");
   end
   if (ADDR_W < 3) begin : g_bad_width
      $error("ADDR_W too small for the register map");
   end

   always_comb begin
      if (addr[ADDR_W-1:2] == BASE_A[ADDR_W-1:2]) region = SEL_FDC;
      else if (addr == HEAD_A)                    region = SEL_HEAD;
      else if (addr == DRV_A)                     region = SEL_DRIVE;
      else if (addr == STAT_A)                    region = SEL_STATUS;
      else                                        region = SEL_NONE;
   end

endmodule

// File: rtl/fdc_glue_latch.sv
module fdc_glue_latch #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_DRIVES = 2,
   parameter int unsigned MOTOR_BIT  = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_head,
   input  logic                  wr_drive,
   input  logic [DATA_W-1:0]     wdata,
   output logic                  side_sel,
   output logic [NUM_DRIVES-1:0] drive_sel,
   output logic                  motor_on
);
   localparam int unsigned SEL_W = $clog2(NUM_DRIVES);

   if (NUM_DRIVES < 2 || (1 << SEL_W) != NUM_DRIVES) begin : g_bad_drives
      $error("NUM_DRIVES must be a power of two, at least 2");
   end
   if (MOTOR_BIT >= DATA_W || SEL_W > MOTOR_BIT) begin : g_bad_motor
      $error("MOTOR_BIT must lie above the drive index inside DATA_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         side_sel  <= 1'b0;
         drive_sel <= NUM_DRIVES'(1);
         motor_on  <= 1'b0;
      end else begin
         if (wr_head) side_sel <= wdata[0];
         if (wr_drive) begin
            drive_sel <= NUM_DRIVES'(1) << wdata[SEL_W-1:0];
            motor_on  <= wdata[MOTOR_BIT];
         end
      end
   end

   // R3
   a_r3_side_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_head |=> side_sel == $past(wdata[0]));
   // R8
   a_r8_side_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_head |=> $stable(side_sel));
   // R4
   a_r4_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(drive_sel) == 1);
   // R5
   a_r5_motor_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drive |=> motor_on == $past(wdata[MOTOR_BIT]));
   // R8
   a_r8_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_drive |=> $stable(drive_sel) && $stable(motor_on));

endmodule

// File: rtl/fdc_glue_rom.sv
module fdc_glue_rom #(
   parameter int unsigned ROM_AW = 14,
   parameter int unsigned DATA_W = 8
) (
   input  logic [ROM_AW-1:0] addr,
   output logic [DATA_W-1:0] data
);
   if (ROM_AW <= DATA_W) begin : g_bad_rom
      $error("ROM_AW must exceed DATA_W for the pattern model");
   end

   logic [ROM_AW-1:0] upper;

   always_comb begin
      upper = addr >> DATA_W;
      data  = addr[DATA_W-1:0] ^ DATA_W'(upper);
   end

endmodule

// File: rtl/fdc_glue_top.sv
module fdc_glue_top
   import fdc_glue_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ROM_AW     = 14,
   parameter int unsigned NUM_DRIVES = 2,
   parameter int unsigned FDC_BASE   = 'h7FF8,
   parameter bit          REG_RDATA  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  fdc_cs,
   output logic                  fdc_we,
   output logic [1:0]            fdc_reg,
   output logic [DATA_W-1:0]     fdc_wdata,
   input  logic [DATA_W-1:0]     fdc_rdata,
   input  logic                  fdc_drq,
   input  logic                  fdc_irq,
   output logic                  side_sel,
   output logic [NUM_DRIVES-1:0] drive_sel,
   output logic                  motor_on
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(FDC_BASE + 7);

   if (ROM_AW > ADDR_W) begin : g_bad_rom_aw
      $error("ROM_AW cannot exceed ADDR_W");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must hold the status bits");
   end

   region_e             region;
   logic                wr_head;
   logic                wr_drive;
   logic [DATA_W-1:0]   rom_byte;
   logic [DATA_W-1:0]   rd_mux;

   fdc_glue_decode #(.ADDR_W(ADDR_W), .FDC_BASE(FDC_BASE)) u_decode (
      .addr   (bus_addr),
      .region (region)
   );

   fdc_glue_rom #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_rom (
      .addr (bus_addr[ROM_AW-1:0]),
      .data (rom_byte)
   );

   fdc_glue_latch #(.DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_head   (wr_head),
      .wr_drive  (wr_drive),
      .wdata     (bus_wdata),
      .side_sel  (side_sel),
      .drive_sel (drive_sel),
      .motor_on  (motor_on)
   );

   assign fdc_cs    = (bus_rd || bus_wr) && (region == SEL_FDC);
   assign fdc_we    = bus_wr && (region == SEL_FDC);
   assign fdc_reg   = bus_addr[1:0];
   assign fdc_wdata = bus_wdata;
   assign wr_head   = bus_wr && (region == SEL_HEAD);
   assign wr_drive  = bus_wr && (region == SEL_DRIVE);

   always_comb begin
      case (region)
         SEL_FDC:    rd_mux = fdc_rdata;
         SEL_STATUS: rd_mux = {~fdc_drq, ~fdc_irq, (DATA_W-2)'(0)};
         default:    rd_mux = rom_byte;
      endcase
   end

   if (REG_RDATA) begin : g_reg_rdata
      always_ff @(posedge clk) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_mux;
      end

      // R6
      a_r6_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == STAT_A) |=>
            bus_rdata[DATA_W-3:0] == '0 &&
            bus_rdata[DATA_W-1] == !$past(fdc_drq) &&
            bus_rdata[DATA_W-2] == !$past(fdc_irq));
      // R2
      a_r2_fdc_read: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && fdc_cs) |=> bus_rdata == $past(fdc_rdata));
      // R10
      a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> $stable(bus_rdata));
   end else begin : g_comb_rdata
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end

   // R1: the bus never strobes read and write together
   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
   // R1
   a_r1_cs_fields: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_cs |-> (fdc_reg == bus_addr[1:0]) && (fdc_we == bus_wr) && (bus_rd || bus_wr));
   // R8
   a_r8_no_cs_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && region != SEL_FDC) |-> !fdc_cs && !fdc_we);

endmodule

// File: tb/test_fdc_glue_top.sv
`timescale 1ns/1ps
module test_fdc_glue_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_rdata;
   logic        fdc_cs, fdc_we;
   logic [1:0]  fdc_reg;
   logic [7:0]  fdc_wdata;
   logic [7:0]  fdc_rdata;
   logic        fdc_drq = 1'b0;
   logic        fdc_irq = 1'b0;
   logic        side_sel;
   logic [1:0]  drive_sel;
   logic        motor_on;

   int total = 0;
   int fails = 0;

   always #10 clk = ~clk;

   assign fdc_rdata = 8'hC4 + {6'b0, fdc_reg};

   fdc_glue_top i_fdc_glue_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
      .fdc_cs(fdc_cs), .fdc_we(fdc_we), .fdc_reg(fdc_reg), .fdc_wdata(fdc_wdata),
      .fdc_rdata(fdc_rdata), .fdc_drq(fdc_drq), .fdc_irq(fdc_irq),
      .side_sel(side_sel), .drive_sel(drive_sel), .motor_on(motor_on)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      if (a >= 16'h7FF8 && a <= 16'h7FFB) return 8'hC4 + {6'b0, a[1:0]};
      if (a == 16'h7FFF) return {~fdc_drq, ~fdc_irq, 6'b0};
      return a[7:0] ^ {2'b00, a[13:8]};
   endfunction

   task automatic do_read(input logic [15:0] a, input string req);
      logic [7:0] e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      e = exp_read(a);
      chk("R1 cs on read", {31'b0, fdc_cs}, {31'b0, (a >= 16'h7FF8 && a <= 16'h7FFB)});
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, {24'b0, bus_rdata}, {24'b0, e});
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      logic in_win;
      in_win = (a >= 16'h7FF8 && a <= 16'h7FFB);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #1;
      chk("R1 cs on write", {31'b0, fdc_cs}, {31'b0, in_win});
      if (in_win) begin
         chk("R1 we", {31'b0, fdc_we}, 32'd1);
         chk("R1 reg", {30'b0, fdc_reg}, {30'b0, a[1:0]});
         chk("R1 wdata", {24'b0, fdc_wdata}, {24'b0, d});
      end
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic chk_latch(input string req, input logic s, input logic [1:0] dsel, input logic m);
      chk({req, " side"},  {31'b0, side_sel},  {31'b0, s});
      chk({req, " drive"}, {30'b0, drive_sel}, {30'b0, dsel});
      chk({req, " motor"}, {31'b0, motor_on},  {31'b0, m});
   endtask

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk_latch("R9", 1'b0, 2'b01, 1'b0);
      chk("R9 rdata", {24'b0, bus_rdata}, 32'd0);

      // R3 side select
      do_write(16'h7FFC, 8'h01); chk("R3 side=1", {31'b0, side_sel}, 32'd1);
      do_write(16'h7FFC, 8'hFE); chk("R3 side=0", {31'b0, side_sel}, 32'd0);
      do_write(16'h7FFC, 8'h03); chk("R3 side=1 again", {31'b0, side_sel}, 32'd1);

      // R4 / R5 drive and motor
      do_write(16'h7FFD, 8'h81); chk_latch("R4 R5 d1 on", 1'b1, 2'b10, 1'b1);
      do_write(16'h7FFD, 8'h00); chk_latch("R4 R5 d0 off", 1'b1, 2'b01, 1'b0);
      do_write(16'h7FFD, 8'h80); chk_latch("R4 R5 d0 on", 1'b1, 2'b01, 1'b1);
      do_write(16'h7FFD, 8'h7F); chk_latch("R4 R5 d1 off", 1'b1, 2'b10, 1'b0);
      do_write(16'h7FFD, 8'h81);

      // R1 controller writes across the window
      for (int i = 0; i < 4; i++) do_write(16'h7FF8 + 16'(i), 8'h30 + 8'(i));

      // R8 writes outside the latch range are ignored
      do_write(16'h7FFE, 8'h00); chk_latch("R8 7FFE", 1'b1, 2'b10, 1'b1);
      do_write(16'h7FFF, 8'h00); chk_latch("R8 7FFF", 1'b1, 2'b10, 1'b1);
      do_write(16'h7FF7, 8'h00); chk_latch("R8 7FF7", 1'b1, 2'b10, 1'b1);
      do_write(16'h3FFC, 8'h00); chk_latch("R8 3FFC", 1'b1, 2'b10, 1'b1);
      do_write(16'hFFFD, 8'h00); chk_latch("R8 FFFD", 1'b1, 2'b10, 1'b1);
      // R1 controller writes leave latches alone too
      chk_latch("R8 after fdc writes", 1'b1, 2'b10, 1'b1);

      // R6 status for every request-line combination
      for (int k = 0; k < 4; k++) begin
         fdc_drq = k[1]; fdc_irq = k[0];
         do_read(16'h7FFF, "R6 status");
      end
      fdc_drq = 1'b0; fdc_irq = 1'b1;

      // R2 R6 R7 exhaustive read sweep
      for (int a = 0; a < 65536; a++) begin
         logic [15:0] aa;
         aa = 16'(a);
         if (aa >= 16'h7FF8 && aa <= 16'h7FFB) do_read(aa, "R2 fdc read");
         else if (aa == 16'h7FFF)              do_read(aa, "R6 status sweep");
         else                                  do_read(aa, "R7 rom read");
      end

      // R10 read data holds over idle cycles and writes
      do_read(16'h1234, "R7 rom read before hold");
      held = bus_rdata;
      repeat (5) @(negedge clk);
      chk("R10 hold idle", {24'b0, bus_rdata}, {24'b0, held});
      do_write(16'h7FFC, 8'h00);
      do_write(16'h7FF9, 8'hAA);
      chk("R10 hold after writes", {24'b0, bus_rdata}, {24'b0, held});

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule